// File: doc/BRIEF.md
# Sixteen-Point Transform Sequencer over a Reused Eight-Point Engine

This block produces a 16-point discrete Fourier transform from one 8-point transform engine that it runs twice. Sixteen complex samples are loaded into an input buffer through a valid/ready stream while the block is idle. A start pulse then launches the sequence. The first engine run sees the even-indexed samples and the second run sees the odd-indexed samples. A two-way multiplexer in front of the engine chooses between the two halves. Each engine result is stored in a 16-entry intermediate RAM. A radix-2 combine pass then applies one twiddled butterfly per cycle to the two stored sub-spectra and writes the finished bins into an output buffer. The bins leave on a second valid/ready stream.

Stage changes come only from the engine's completion pulse. That pulse launches the next engine run and flips the input multiplexer, so the block never assumes a fixed engine latency. The engine here is a behavioural stand-in. It computes an 8-point DFT with Q1.14 twiddles and waits a number of cycles given on the `stub_lat` pin before it emits its eight bins, one per cycle. Its last bin carries a done pulse.

Back-pressure rules: `in_ready` is high only while the block is idle, and a sample moves on any cycle where `in_valid` and `in_ready` are both high. On `out_*`, a bin counts as taken on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low the offered bin, its index and `out_valid` hold still.

Top module: `fft16_seq`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: While idle, each accepted sample goes into the input buffer at the next index, starting at 0. The index wraps after 15 and returns to 0 whenever a start is accepted.
- R3: `start` is acted on only while idle. A start pulse or `in_valid` during a transform changes neither the sequence nor the buffered samples, and `in_ready` stays 0 for the whole transform.
- R4: The engine receives exactly one single-cycle start pulse per run, in the cycle after the sequencer enters each of its two run stages.
- R5: Each engine done pulse moves the sequence to the next stage, with no fixed cycle count. For a stand-in latency L, `done` rises 2L+28 clock edges after the edge that samples `start`.
- R6: The first run transforms the even samples x[0], x[2], …, x[14]. The second run transforms the odd samples. Their bins are stored at intermediate addresses 0–7 and 8–15 respectively.
- R7: The combine pass forms bin k and bin k+8 (k = 0…7) as A[k] ± W16^k·B[k]. Each output bin, real and imaginary, is within 6 units of Σ x[n]·e^(−j2πkn/16).
- R8: `done` is high for exactly one cycle per transform, and that cycle is the first one in which `out_valid` is high.
- R9: The bins leave in order 0 to 15, with `out_idx` giving the bin number. Under back-pressure, data and index hold stable. After bin 15 is taken the block returns to idle with `in_ready` at 1.
- R10: The input buffer keeps its contents after a transform, so a new start without reloading yields the same spectrum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transform (acted on only while idle) |
| done | output | 1 | One-cycle pulse when the spectrum is ready |
| stub_lat | input | LW | Wait cycles of the stand-in engine before it emits |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted (high only while idle) |
| in_re | input | DW | Input sample, real part, signed |
| in_im | input | DW | Input sample, imaginary part, signed |
| out_valid | output | 1 | Output bin valid |
| out_ready | input | 1 | Downstream takes the offered bin |
| out_re | output | DW+4 | Output bin, real part, signed |
| out_im | output | DW+4 | Output bin, imaginary part, signed |
| out_idx | output | 4 | Index of the offered bin |

## Verification
The completion pulse is due exactly 2L+28 edges after the edge that samples `start`. The bench counts edges from that point and reads `done` on each falling edge, so an extra or missing register stage in any path shows up as a wrong count. Once `done` is seen, bin 0 is already offered. Each later bin appears one edge after the previous handshake, so the bench reads one bin per falling edge while `out_ready` is held high. During deliberate stalls it checks that the offered bin does not move. The return to idle is checked on the falling edge right after the handshake of bin 15.

// File: rtl/fft16_seq_pkg.sv
package fft16_seq_pkg;

  localparam int NE  = 8;   // points per engine run
  localparam int NT  = 16;  // points of the full transform
  localparam int TWW = 16;  // twiddle word width
  localparam int TWF = 14;  // twiddle fraction bits (1.0 = 16384)

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN_LOW,
    ST_RUN_HIGH,
    ST_COMBINE,
    ST_DONE
  } seq_state_t;

  // sin(2*pi*k/16) in Q1.14, built from the first quadrant by symmetry
  function automatic logic signed [TWW-1:0] tw_sin(input logic [3:0] k);
    logic [2:0] lo;
    logic [2:0] q;
    logic signed [TWW-1:0] mag;
    lo = k[2:0];
    q  = (lo <= 3'd4) ? lo : 3'(4'd8 - {1'b0, lo});
    case (q)
      3'd0:    mag = 16'sd0;
      3'd1:    mag = 16'sd6270;
      3'd2:    mag = 16'sd11585;
      3'd3:    mag = 16'sd15137;
      default: mag = 16'sd16384;
    endcase
    return k[3] ? -mag : mag;
  endfunction

  function automatic logic signed [TWW-1:0] tw_cos(input logic [3:0] k);
    return tw_sin(k + 4'd4);
  endfunction

endpackage

// File: rtl/fft16_seq_eng.sv
// Behavioural stand-in for the 8-point transform engine.
module fft16_seq_eng
  import fft16_seq_pkg::*;
#(
  parameter int DW = 18,
  parameter int EW = DW + 3,
  parameter int LW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LW-1:0]        lat,
  input  logic signed [DW-1:0] din_re [NE],
  input  logic signed [DW-1:0] din_im [NE],
  output logic                 res_valid,
  output logic [2:0]           res_idx,
  output logic signed [EW-1:0] res_re,
  output logic signed [EW-1:0] res_im,
  output logic                 done
);

  localparam int AW = DW + TWW + 4;

  typedef enum logic [1:0] {E_IDLE, E_WAIT, E_EMIT} eng_state_t;

  eng_state_t            est;
  logic [LW-1:0]         cnt;
  logic [2:0]            idx;
  logic signed [DW-1:0]  cap_re [NE];
  logic signed [DW-1:0]  cap_im [NE];
  logic signed [AW-1:0]  acc_re, acc_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est <= E_IDLE;
      cnt <= '0;
      idx <= '0;
    end else begin
      case (est)
        E_IDLE: if (start) begin
          est <= E_WAIT;
          cnt <= lat;
        end
        E_WAIT: if (cnt == '0) begin
          est <= E_EMIT;
          idx <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: begin
          idx <= idx + 1'b1;
          if (idx == 3'd7) est <= E_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (est == E_IDLE && start) begin
      cap_re <= din_re;
      cap_im <= din_im;
    end
  end

  // bin idx = sum of x[n] * W8^(idx*n) = W16^(2*idx*n)
  always_comb begin
    logic [3:0] ti;
    acc_re = '0;
    acc_im = '0;
    for (int n = 0; n < NE; n++) begin
      ti = 4'(2 * int'(idx) * n);
      acc_re = acc_re + AW'(cap_re[n]) * AW'(tw_cos(ti))
                      + AW'(cap_im[n]) * AW'(tw_sin(ti));
      acc_im = acc_im + AW'(cap_im[n]) * AW'(tw_cos(ti))
                      - AW'(cap_re[n]) * AW'(tw_sin(ti));
    end
  end

  assign res_valid = (est == E_EMIT);
  assign res_idx   = idx;
  assign res_re    = EW'(acc_re >>> TWF);
  assign res_im    = EW'(acc_im >>> TWF);
  assign done      = (est == E_EMIT) && (idx == 3'd7);

endmodule

// File: rtl/fft16_seq_ram.sv
// Intermediate store: one write port, two asynchronous read ports.
module fft16_seq_ram #(
  parameter int W     = 21,
  parameter int DEPTH = 16,
  parameter int AWD   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AWD-1:0]      wr_addr,
  input  logic signed [W-1:0] wr_re,
  input  logic signed [W-1:0] wr_im,
  input  logic [AWD-1:0]      ra_addr,
  output logic signed [W-1:0] ra_re,
  output logic signed [W-1:0] ra_im,
  input  logic [AWD-1:0]      rb_addr,
  output logic signed [W-1:0] rb_re,
  output logic signed [W-1:0] rb_im
);

  logic signed [W-1:0] mem_re [DEPTH];
  logic signed [W-1:0] mem_im [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_re[wr_addr] <= wr_re;
      mem_im[wr_addr] <= wr_im;
    end
  end

  assign ra_re = mem_re[ra_addr];
  assign ra_im = mem_im[ra_addr];
  assign rb_re = mem_re[rb_addr];
  assign rb_im = mem_im[rb_addr];

endmodule

// File: rtl/fft16_seq_bfly.sv
// Radix-2 combine butterfly: p = a + W16^k*b, m = a - W16^k*b.
module fft16_seq_bfly
  import fft16_seq_pkg::*;
#(
  parameter int EW = 21,
  parameter int OW = EW + 1
) (
  input  logic [2:0]           k,
  input  logic signed [EW-1:0] a_re,
  input  logic signed [EW-1:0] a_im,
  input  logic signed [EW-1:0] b_re,
  input  logic signed [EW-1:0] b_im,
  output logic signed [OW-1:0] p_re,
  output logic signed [OW-1:0] p_im,
  output logic signed [OW-1:0] m_re,
  output logic signed [OW-1:0] m_im
);

  localparam int PW = EW + TWW + 1;

  logic signed [TWW-1:0] wc, ws;
  logic signed [PW-1:0]  pr, pi;
  logic signed [OW-1:0]  t_re, t_im, ax_re, ax_im;

  assign wc = tw_cos({1'b0, k});
  assign ws = tw_sin({1'b0, k});

  // b * (cos - j sin)
  assign pr = PW'(b_re) * PW'(wc) + PW'(b_im) * PW'(ws);
  assign pi = PW'(b_im) * PW'(wc) - PW'(b_re) * PW'(ws);

  assign t_re  = OW'(pr >>> TWF);
  assign t_im  = OW'(pi >>> TWF);
  assign ax_re = OW'(a_re);
  assign ax_im = OW'(a_im);

  assign p_re = ax_re + t_re;
  assign p_im = ax_im + t_im;
  assign m_re = ax_re - t_re;
  assign m_im = ax_im - t_im;

endmodule

// File: rtl/fft16_seq.sv
module fft16_seq
  import fft16_seq_pkg::*;
#(
  parameter int DW = 18,
  parameter int LW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 done,
  input  logic [LW-1:0]        stub_lat,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW+3:0] out_re,
  output logic signed [DW+3:0] out_im,
  output logic [3:0]           out_idx
);

  localparam int EW = DW + 3;
  localparam int OW = DW + 4;

  seq_state_t            state;
  logic                  kick;
  logic [3:0]            wr_ptr;
  logic [2:0]            ck;
  logic [3:0]            oidx;
  logic                  done_r;
  logic                  half;

  logic signed [DW-1:0]  ib_re [NT];
  logic signed [DW-1:0]  ib_im [NT];
  logic signed [DW-1:0]  mx_re [NE];
  logic signed [DW-1:0]  mx_im [NE];

  logic                  eng_start, eng_done, eng_vld;
  logic [2:0]            eng_idx;
  logic signed [EW-1:0]  eng_re, eng_im;

  logic signed [EW-1:0]  a_re, a_im, b_re, b_im;
  logic signed [OW-1:0]  p_re, p_im, m_re, m_im;
  logic signed [OW-1:0]  ob_re [NT];
  logic signed [OW-1:0]  ob_im [NT];

  assign half      = (state == ST_RUN_HIGH);
  assign eng_start = kick;

  // input half select: even samples on the low run, odd on the high run
  for (genvar g = 0; g < NE; g++) begin : g_mux
    assign mx_re[g] = half ? ib_re[2*g+1] : ib_re[2*g];
    assign mx_im[g] = half ? ib_im[2*g+1] : ib_im[2*g];
  end

  fft16_seq_eng #(.DW(DW), .EW(EW), .LW(LW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .lat       (stub_lat),
    .din_re    (mx_re),
    .din_im    (mx_im),
    .res_valid (eng_vld),
    .res_idx   (eng_idx),
    .res_re    (eng_re),
    .res_im    (eng_im),
    .done      (eng_done)
  );

  fft16_seq_ram #(.W(EW), .DEPTH(NT)) u_ram (
    .clk     (clk),
    .wr_en   (eng_vld),
    .wr_addr ({half, eng_idx}),
    .wr_re   (eng_re),
    .wr_im   (eng_im),
    .ra_addr ({1'b0, ck}),
    .ra_re   (a_re),
    .ra_im   (a_im),
    .rb_addr ({1'b1, ck}),
    .rb_re   (b_re),
    .rb_im   (b_im)
  );

  fft16_seq_bfly #(.EW(EW), .OW(OW)) u_bfly (
    .k    (ck),
    .a_re (a_re),
    .a_im (a_im),
    .b_re (b_re),
    .b_im (b_im),
    .p_re (p_re),
    .p_im (p_im),
    .m_re (m_re),
    .m_im (m_im)
  );

  // stage sequencing: every step after start is released by the engine's done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kick   <= 1'b0;
      wr_ptr <= '0;
      ck     <= '0;
      oidx   <= '0;
      done_r <= 1'b0;
    end else begin
      kick   <= 1'b0;
      done_r <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) wr_ptr <= wr_ptr + 1'b1;
          if (start) begin
            state  <= ST_RUN_LOW;
            kick   <= 1'b1;
            wr_ptr <= '0;
          end
        end
        ST_RUN_LOW: if (eng_done) begin
          state <= ST_RUN_HIGH;
          kick  <= 1'b1;
        end
        ST_RUN_HIGH: if (eng_done) begin
          state <= ST_COMBINE;
          ck    <= '0;
        end
        ST_COMBINE: begin
          ck <= ck + 1'b1;
          if (ck == 3'd7) begin
            state  <= ST_DONE;
            done_r <= 1'b1;
            oidx   <= '0;
          end
        end
        default: if (out_ready) begin
          oidx <= oidx + 1'b1;
          if (oidx == 4'd15) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_IDLE && in_valid) begin
      ib_re[wr_ptr] <= in_re;
      ib_im[wr_ptr] <= in_im;
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_COMBINE) begin
      ob_re[{1'b0, ck}] <= p_re;
      ob_im[{1'b0, ck}] <= p_im;
      ob_re[{1'b1, ck}] <= m_re;
      ob_im[{1'b1, ck}] <= m_im;
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_re    = ob_re[oidx];
  assign out_im    = ob_im[oidx];
  assign out_idx   = oidx;
  assign done      = done_r;

endmodule

// File: rtl/fft16_seq_chk.sv
module fft16_seq_chk
  import fft16_seq_pkg::*;
#(
  parameter int OW = 22
) (
  input logic                 clk,
  input logic                 rst_n,
  input seq_state_t           state,
  input logic                 eng_start,
  input logic                 eng_done,
  input logic                 start,
  input logic                 done,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im,
  input logic [3:0]           out_idx
);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_start_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_LOW && $past(state) == ST_IDLE) |-> eng_start);

  p_done_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && state == ST_RUN_LOW) |=> (state == ST_RUN_HIGH && eng_start));

  p_done_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> (state == ST_RUN_LOW || state == ST_RUN_HIGH));

  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_COMBINE) |=> (state == ST_COMBINE || state == ST_DONE));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && out_idx == 4'd0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_idx)));

  p_last_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_idx == 4'd15) |=> in_ready);

endmodule

bind fft16_seq fft16_seq_chk #(.OW(OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (state),
  .eng_start (eng_start),
  .eng_done  (eng_done),
  .start     (start),
  .done      (done),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_re    (out_re),
  .out_im    (out_im),
  .out_idx   (out_idx)
);

// File: tb/fft16_seq_tb.sv
`timescale 1ns/1ps
module fft16_seq_tb;

  localparam int DW = 18;
  localparam int LW = 8;
  localparam int OW = DW + 4;
  localparam real PI = 3.14159265358979;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic                 done;
  logic [LW-1:0]        stub_lat = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b0;
  logic signed [OW-1:0] out_re;
  logic signed [OW-1:0] out_im;
  logic [3:0]           out_idx;

  int  checks = 0;
  int  failures = 0;
  int  dn_cnt = 0;
  int  xr [16];
  int  xi [16];
  real er [16];
  real ei [16];

  always #2.5 clk = ~clk;

  fft16_seq #(.DW(DW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .stub_lat(stub_lat), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
    .out_idx(out_idx)
  );

  always @(negedge clk) if (rst_n && done) dn_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ref_dft();
    for (int k = 0; k < 16; k++) begin
      er[k] = 0.0;
      ei[k] = 0.0;
      for (int n = 0; n < 16; n++) begin
        real th;
        th = 2.0 * PI * k * n / 16.0;
        er[k] += xr[n] * $cos(th) + xi[n] * $sin(th);
        ei[k] += xi[n] * $cos(th) - xr[n] * $sin(th);
      end
    end
  endtask

  function automatic bit near(input int act, input real exp);
    real d;
    d = act - exp;
    return (d <= 6.0) && (d >= -6.0);
  endfunction

  // R2: stream the 16 samples in order
  task automatic load_samples();
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R2", "in_ready while loading", int'(in_ready), 1);
      in_valid = 1'b1;
      in_re = DW'(xr[n]);
      in_im = DW'(xi[n]);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R5, R7, R8, R9 (R3 disturbances when busy=1, stall when bp=1)
  task automatic run_check(input int lat, input bit bp, input bit busy,
                           input string tag);
    int cyc;
    int d0;
    logic signed [OW-1:0] hr, hi;
    d0 = dn_cnt;
    stub_lat = LW'(lat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (busy && (cyc == 3 || cyc == lat + 12 || cyc == 2 * lat + 22)) begin
        chk(in_ready == 1'b0, "R3", "in_ready during transform", int'(in_ready), 0);
        start = 1'b1;
        in_valid = 1'b1;
        in_re = 18'sd12345;
        in_im = -18'sd9999;
      end else begin
        start = 1'b0;
        in_valid = 1'b0;
      end
    end
    chk(cyc == 2 * lat + 28, "R5", {tag, " done latency"}, cyc, 2 * lat + 28);
    chk(out_valid == 1'b1, "R8", {tag, " out_valid with done"}, int'(out_valid), 1);
    if (bp) begin
      hr = out_re;
      hi = out_im;
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        chk(out_valid && out_idx == 4'd0 && out_re == hr && out_im == hi,
            "R9", {tag, " stall hold idx"}, int'(out_idx), 0);
        chk(done == 1'b0, "R8", {tag, " done single cycle"}, int'(done), 0);
      end
    end
    out_ready = 1'b1;
    for (int b = 0; b < 16; b++) begin
      chk(out_valid == 1'b1 && out_idx == 4'(b), "R9", {tag, " bin order"},
          int'(out_idx), b);
      chk(near(int'(out_re), er[b]), "R7", {tag, " bin re"}, int'(out_re), $rtoi(er[b]));
      chk(near(int'(out_im), ei[b]), "R7", {tag, " bin im"}, int'(out_im), $rtoi(ei[b]));
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9", {tag, " back to idle"},
        int'(in_ready), 1);
    chk(dn_cnt - d0 == 1, "R8", {tag, " done pulses"}, dn_cnt - d0, 1);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
  endtask

  task automatic t_impulse();       // R6/R7 flat spectrum, L=0
    for (int n = 0; n < 16; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 500;
    ref_dft();
    load_samples();
    run_check(0, 1'b0, 1'b0, "impulse");
  endtask

  task automatic t_tone();          // R6/R7 single bin 3, L=5
    for (int n = 0; n < 16; n++) begin
      xr[n] = $rtoi(800.0 * $cos(2.0 * PI * 3 * n / 16.0));
      xi[n] = $rtoi(800.0 * $sin(2.0 * PI * 3 * n / 16.0));
    end
    ref_dft();
    load_samples();
    run_check(5, 1'b0, 1'b0, "tone");
  endtask

  task automatic t_mixed_stall();   // R7/R9 irregular data with stall, L=13
    for (int n = 0; n < 16; n++) begin
      xr[n] = (n * 37) % 200 - 100;
      xi[n] = (n * 53) % 150 - 75;
    end
    ref_dft();
    load_samples();
    run_check(13, 1'b1, 1'b0, "mixed");
  endtask

  task automatic t_busy();          // R3 start/in_valid ignored while busy, L=2
    for (int n = 0; n < 16; n++) begin
      xr[n] = (n % 2 == 0) ? 700 : -700;
      xi[n] = n * 20 - 150;
    end
    ref_dft();
    load_samples();
    run_check(2, 1'b0, 1'b1, "busy");
  endtask

  task automatic t_rerun();         // R10 buffer retained, new latency L=7
    run_check(7, 1'b0, 1'b0, "rerun");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_impulse();
    t_tone();
    t_mixed_stall();
    t_busy();
    t_rerun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R5 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule